// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits beside a receive datapath and decides whether an incoming Ethernet frame is kept, based only on the destination address (DA). The six DA bytes arrive one per valid strobe, in wire order. A start-of-frame flag marks the first of them. While the bytes stream past, the block runs a CRC-32 over them and keeps a copy of the address. When the sixth byte has been taken, it produces a one-cycle verdict.

The verdict follows a small set of configuration inputs. Unicast and multicast frames each have their own choice between a 64-bit hash table and one programmed exact-match address. The hash table is held as two 32-bit words. Three more controls sit on top of that choice: an inverse option that flips the comparison outcome, a pass-all-multicast override and a promiscuous override. Alongside the accept flag the block raises a DA-filter-fail status bit for the receive status word.

Top module: `da_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_vld`, `dec_accept` and `dec_fail` are all 0.
- R2: A byte taken with `byte_vld` and `byte_sof` both high starts a new address, and that restart can happen at any point in an earlier one. Exactly five further valid bytes complete the address. `dec_vld` is high for exactly the one cycle after the sixth byte is taken. Valid bytes that arrive after the sixth and before the next start-of-frame are ignored.
- R3: The hash index is the complement of the top six bits of a CRC-32. The CRC uses polynomial 0x04C11DB7 and starts from all ones. Each byte is fed least significant bit first. Index bit 5 chooses `cfg_hash_hi` (1) or `cfg_hash_lo` (0), and index bits 4:0 give the bit number. The DA bytes 1F 52 41 9C B6 AF give index 0x2C (high word, bit 12). The DA bytes A0 0A 98 00 00 45 give index 0x07 (low word, bit 7).
- R4: When a frame is looked up in the hash table, it matches if the selected table bit is 1 and fails to match if it is 0.
- R5: A frame is multicast when bit 0 of its first DA byte is 1, and this includes broadcast. For multicast frames, `cfg_hash_mc`=1 selects the hash lookup and 0 selects exact comparison.
- R6: For unicast frames, `cfg_hash_uc`=1 selects the hash lookup and 0 selects exact comparison. Each bit affects only its own frame class.
- R7: Exact comparison matches when all six DA bytes equal `cfg_addr`. `cfg_addr[47:40]` is compared with the first received byte and `cfg_addr[7:0]` with the sixth.
- R8: With `cfg_pass_mcast`=1, every multicast frame is accepted whatever its lookup result. Unicast frames are unaffected.
- R9: With `cfg_inverse`=1, a frame is accepted when its lookup or comparison does not match and rejected when it does. This holds for both frame classes.
- R10: With `cfg_promisc`=1, every frame is accepted and `dec_fail` is 0.
- R11: When `dec_vld` is high and promiscuous mode is off, `dec_fail` is the complement of `dec_accept`.
- R12: Cycles with `byte_vld` low between DA bytes change nothing: the verdict equals the one for the same bytes sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_vld | input | 1 | A DA byte is present this cycle |
| byte_sof | input | 1 | The present byte is the first DA byte |
| byte_data | input | 8 | DA byte |
| cfg_promisc | input | 1 | Accept every frame, clear fail status |
| cfg_pass_mcast | input | 1 | Accept every multicast frame |
| cfg_hash_uc | input | 1 | Unicast uses the hash table |
| cfg_hash_mc | input | 1 | Multicast uses the hash table |
| cfg_inverse | input | 1 | Invert the match outcome |
| cfg_addr | input | 48 | Exact-match address, first byte in bits 47:40 |
| cfg_hash_hi | input | 32 | Hash table bits 63:32 |
| cfg_hash_lo | input | 32 | Hash table bits 31:0 |
| dec_vld | output | 1 | Verdict valid, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_fail | output | 1 | DA filter failed status |

## Verification
The hardest condition to reach from the ports is a lookup of one particular hash bit, because the index exists only inside the CRC. The stimulus uses the two known address vectors. It first checks that a bench-side serial CRC model reproduces their indices. It then arms exactly the one selected table bit, and after that every bit except that one. A wrong index, bit order or word select therefore flips the verdict. A mid-address restart and strobes with gaps are driven on purpose, so that stale bytes would corrupt either the exact comparison or the CRC.

// File: rtl/da_filter_pkg.sv
// Package: shared constants and the byte-wide CRC step for the DA filter.
// Assumes bytes are fed least significant bit first, CRC kept in MSB-first form.
package da_filter_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Advance the CRC register by one byte, bit 0 of the byte first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                  input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/da_capture.sv
// Module: da_capture
// Counts DA bytes from start-of-frame, collects the address, records the
// multicast flag and pulses done one cycle after the last byte is taken.
// Assumes a start-of-frame byte always restarts, and extra bytes are dropped.
module da_capture #(
    parameter int N_BYTES = 6,
    localparam int ADDR_W = 8 * N_BYTES,
    localparam int CNT_W  = $clog2(N_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_sof,
    input  logic [7:0]        byte_data,
    output logic              take_first,
    output logic              take_next,
    output logic [ADDR_W-1:0] addr,
    output logic              mcast,
    output logic              done
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_BYTES - 1);

    logic [CNT_W-1:0] cnt;

    // Classify the present byte as first, continuing or ignored.
    always_comb begin
        take_first = byte_vld && byte_sof;
        take_next  = byte_vld && !byte_sof && (cnt != '0) && (cnt < CNT_FULL);
    end

    // Track position, shift in address bytes, raise done after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            addr  <= '0;
            mcast <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= (take_first && (N_BYTES == 1)) || (take_next && (cnt == CNT_LAST));
            if (take_first) begin
                cnt   <= CNT_W'(1);
                addr  <= {{(ADDR_W-8){1'b0}}, byte_data};
                mcast <= byte_data[0];
            end else if (take_next) begin
                cnt  <= cnt + CNT_W'(1);
                addr <= {addr[ADDR_W-9:0], byte_data};
            end
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/da_crc.sv
// Module: da_crc
// Runs CRC-32 over the DA bytes and presents the hash index taken from the
// complemented top bits. Assumes seed and step are never high together.
module da_crc #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed,
    input  logic             step,
    input  logic [7:0]       data,
    output logic [IDX_W-1:0] idx
);
    import da_filter_pkg::*;

    logic [31:0] crc_q;

    // Restart from the seed on the first byte, otherwise fold bytes in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (seed) begin
            crc_q <= crc_step_byte(CRC_SEED, data);
        end else if (step) begin
            crc_q <= crc_step_byte(crc_q, data);
        end
    end

    // Index is the inverted upper CRC bits.
    always_comb idx = ~crc_q[31 -: IDX_W];

    a_r12_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(seed || step) |=> $stable(crc_q));

endmodule

// File: rtl/da_decide.sv
// Module: da_decide
// Combines lookup and exact comparison with the mode controls into raw
// accept and fail flags. Assumes its inputs are stable while done is high.
module da_decide #(
    parameter int ADDR_W = 48,
    parameter int HASH_BITS = 64,
    localparam int IDX_W = $clog2(HASH_BITS)
) (
    input  logic                 cfg_promisc,
    input  logic                 cfg_pass_mcast,
    input  logic                 cfg_hash_uc,
    input  logic                 cfg_hash_mc,
    input  logic                 cfg_inverse,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [HASH_BITS-1:0] table_bits,
    input  logic [IDX_W-1:0]     idx,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 mcast,
    output logic                 accept_raw,
    output logic                 fail_raw
);

    logic use_hash;
    logic hit;
    logic pass;

    // Pick the test for this frame class and form the verdict.
    always_comb begin
        use_hash   = mcast ? cfg_hash_mc : cfg_hash_uc;
        hit        = use_hash ? table_bits[idx] : (addr == cfg_addr);
        pass       = (mcast && cfg_pass_mcast) || (hit ^ cfg_inverse);
        accept_raw = cfg_promisc || pass;
        fail_raw   = !cfg_promisc && !pass;
    end

endmodule

// File: rtl/da_filter.sv
// Module: da_filter (top)
// Destination address filter: capture, CRC hashing and verdict.
// Assumes configuration is held steady while a frame's DA arrives.
module da_filter #(
    parameter int DA_BYTES  = 6,
    parameter int HASH_BITS = 64,
    localparam int ADDR_W = 8 * DA_BYTES,
    localparam int WORD_W = HASH_BITS / 2,
    localparam int IDX_W  = $clog2(HASH_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_sof,
    input  logic [7:0]        byte_data,
    input  logic              cfg_promisc,
    input  logic              cfg_pass_mcast,
    input  logic              cfg_hash_uc,
    input  logic              cfg_hash_mc,
    input  logic              cfg_inverse,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_hash_hi,
    input  logic [WORD_W-1:0] cfg_hash_lo,
    output logic              dec_vld,
    output logic              dec_accept,
    output logic              dec_fail
);

    logic              take_first;
    logic              take_next;
    logic [ADDR_W-1:0] addr;
    logic              mcast;
    logic              done;
    logic [IDX_W-1:0]  idx;
    logic              accept_raw;
    logic              fail_raw;

    da_capture #(.N_BYTES(DA_BYTES)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_sof  (byte_sof),
        .byte_data (byte_data),
        .take_first(take_first),
        .take_next (take_next),
        .addr      (addr),
        .mcast     (mcast),
        .done      (done)
    );

    da_crc #(.IDX_W(IDX_W)) u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (take_first),
        .step (take_next),
        .data (byte_data),
        .idx  (idx)
    );

    da_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_dec (
        .cfg_promisc   (cfg_promisc),
        .cfg_pass_mcast(cfg_pass_mcast),
        .cfg_hash_uc   (cfg_hash_uc),
        .cfg_hash_mc   (cfg_hash_mc),
        .cfg_inverse   (cfg_inverse),
        .cfg_addr      (cfg_addr),
        .table_bits    ({cfg_hash_hi, cfg_hash_lo}),
        .idx           (idx),
        .addr          (addr),
        .mcast         (mcast),
        .accept_raw    (accept_raw),
        .fail_raw      (fail_raw)
    );

    // Present the verdict only in the done cycle.
    always_comb begin
        dec_vld    = done;
        dec_accept = done && accept_raw;
        dec_fail   = done && fail_raw;
    end

    a_r10_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && cfg_promisc) |-> (dec_accept && !dec_fail));

    a_r11_fail_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !cfg_promisc) |-> (dec_accept != dec_fail));

    a_r8_pass_mcast: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && mcast && cfg_pass_mcast) |-> dec_accept);

    a_r2_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (!dec_accept && !dec_fail));

endmodule

// File: tb/sim_da_filter.sv
// Directed bench for da_filter: one task per scenario, each checks itself.
module sim_da_filter;

    localparam real HALF = 4.0;  // 125 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic        byte_sof = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        cfg_promisc = 1'b0;
    logic        cfg_pass_mcast = 1'b0;
    logic        cfg_hash_uc = 1'b0;
    logic        cfg_hash_mc = 1'b0;
    logic        cfg_inverse = 1'b0;
    logic [47:0] cfg_addr = '0;
    logic [31:0] cfg_hash_hi = '0;
    logic [31:0] cfg_hash_lo = '0;
    logic        dec_vld;
    logic        dec_accept;
    logic        dec_fail;

    int tests = 0;
    int fails = 0;

    localparam logic [47:0] DA_V1 = 48'h1F52_419C_B6AF;  // multicast
    localparam logic [47:0] DA_V2 = 48'hA00A_9800_0045;  // unicast
    localparam logic [47:0] DA_U3 = 48'h0211_2233_4455;  // other unicast
    localparam logic [47:0] DA_BC = 48'hFFFF_FFFF_FFFF;

    always #(HALF) clk = ~clk;

    da_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_data(byte_data),
        .cfg_promisc(cfg_promisc), .cfg_pass_mcast(cfg_pass_mcast),
        .cfg_hash_uc(cfg_hash_uc), .cfg_hash_mc(cfg_hash_mc),
        .cfg_inverse(cfg_inverse), .cfg_addr(cfg_addr),
        .cfg_hash_hi(cfg_hash_hi), .cfg_hash_lo(cfg_hash_lo),
        .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_fail(dec_fail)
    );

    // Reference hash index: reflected serial CRC-32, complemented, bit-reversed low six bits.
    function automatic logic [5:0] ref_index(input logic [47:0] da);
        logic [31:0] r;
        logic [31:0] c;
        logic [7:0]  b;
        logic        lsb;
        r = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            b = da[47 - 8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                lsb = r[0] ^ b[k];
                r   = r >> 1;
                if (lsb) r = r ^ 32'hEDB8_8320;
            end
        end
        c = ~r;
        return {c[0], c[1], c[2], c[3], c[4], c[5]};
    endfunction

    task automatic set_cfg(input logic pr, input logic pam, input logic huc,
                           input logic hmc, input logic inv, input logic [47:0] a,
                           input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        cfg_promisc = pr; cfg_pass_mcast = pam; cfg_hash_uc = huc;
        cfg_hash_mc = hmc; cfg_inverse = inv; cfg_addr = a;
        cfg_hash_hi = hi; cfg_hash_lo = lo;
    endtask

    // Drive the six DA bytes; leaves time just after the capture edge.
    task automatic send_da(input logic [47:0] da, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_sof = (i == 0); byte_data = da[47 - 8*i -: 8];
            if (gaps && i < 5) begin
                @(negedge clk);
                byte_vld = 1'b0; byte_sof = 1'b0; byte_data = 8'h5A;
            end
        end
        @(negedge clk);
        byte_vld = 1'b0; byte_sof = 1'b0;
    endtask

    task automatic expect_dec(input string tag, input logic ea, input logic ef);
        tests++;
        if (dec_vld !== 1'b1 || dec_accept !== ea || dec_fail !== ef) begin
            fails++;
            $display("FAIL %s: vld/acc/fail got %b%b%b exp 1%b%b",
                     tag, dec_vld, dec_accept, dec_fail, ea, ef);
        end
    endtask

    task automatic frame(input string tag, input logic [47:0] da, input logic ea, input logic ef);
        send_da(da, 1'b0);
        expect_dec(tag, ea, ef);
    endtask

    task automatic t_reset;
        @(negedge clk);
        tests++;
        if (dec_vld !== 1'b0 || dec_accept !== 1'b0 || dec_fail !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: got %b%b%b exp 000", dec_vld, dec_accept, dec_fail);
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (dec_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: dec_vld %b exp 0", dec_vld);
        end
    endtask

    task automatic t_hash;
        tests++;
        if (ref_index(DA_V1) != 6'h2C || ref_index(DA_V2) != 6'h07) begin
            fails++;
            $display("FAIL R3 model: got %h %h exp 2c 07", ref_index(DA_V1), ref_index(DA_V2));
        end
        // R3 R4 R5: multicast vector hits high word bit 12
        set_cfg(0, 0, 0, 1, 0, DA_U3, 32'h0000_1000, 32'h0);
        frame("R3 R4 mc hash bit set", DA_V1, 1, 0);
        set_cfg(0, 0, 0, 1, 0, DA_U3, ~32'h0000_1000, 32'hFFFF_FFFF);
        frame("R3 R4 mc hash bit clear", DA_V1, 0, 1);
        set_cfg(0, 0, 0, 0, 0, DA_U3, 32'h0000_1000, 32'h0);
        frame("R5 mc perfect mismatch", DA_V1, 0, 1);
        // R3 R6: unicast vector hits low word bit 7
        set_cfg(0, 0, 1, 0, 0, DA_U3, 32'h0, 32'h0000_0080);
        frame("R3 R6 uc hash bit set", DA_V2, 1, 0);
        set_cfg(0, 0, 1, 0, 0, DA_U3, 32'hFFFF_FFFF, ~32'h0000_0080);
        frame("R3 R6 uc hash bit clear", DA_V2, 0, 1);
        set_cfg(0, 0, 0, 1, 0, DA_U3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        frame("R6 uc ignores hash_mc", DA_V2, 0, 1);
        // R5: broadcast is multicast
        begin
            logic [5:0] bi;
            logic [63:0] t;
            bi = ref_index(DA_BC);
            t = 64'd1 << bi;
            set_cfg(0, 0, 0, 1, 0, DA_U3, t[63:32], t[31:0]);
            frame("R5 broadcast hashed", DA_BC, 1, 0);
        end
    endtask

    task automatic t_perfect;
        set_cfg(0, 0, 0, 0, 0, DA_V2, 32'h0, 32'h0);
        frame("R7 uc exact match", DA_V2, 1, 0);
        set_cfg(0, 0, 0, 0, 0, DA_V2 ^ 48'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        frame("R7 last byte differs", DA_V2, 0, 1);
        set_cfg(0, 0, 0, 0, 0, DA_V2 ^ 48'h0100_0000_0000, 32'h0, 32'h0);
        frame("R7 first byte differs", DA_V2, 0, 1);
        set_cfg(0, 0, 0, 0, 0, DA_V1, 32'h0, 32'h0);
        frame("R7 mc exact match", DA_V1, 1, 0);
    endtask

    task automatic t_pass_mcast;
        set_cfg(0, 1, 0, 1, 0, DA_U3, 32'h0, 32'h0);
        frame("R8 mc passed", DA_V1, 1, 0);
        set_cfg(0, 1, 0, 0, 0, DA_U3, 32'h0, 32'h0);
        frame("R8 uc not passed", DA_V2, 0, 1);
    endtask

    task automatic t_inverse;
        set_cfg(0, 0, 0, 0, 1, DA_V2, 32'h0, 32'h0);
        frame("R9 inverse exact hit", DA_V2, 0, 1);
        frame("R9 inverse exact miss", DA_U3, 1, 0);
        set_cfg(0, 0, 0, 1, 1, DA_U3, 32'h0000_1000, 32'h0);
        frame("R9 inverse hash hit", DA_V1, 0, 1);
    endtask

    task automatic t_promisc;
        set_cfg(1, 0, 1, 1, 0, DA_U3, 32'h0, 32'h0);
        frame("R10 promisc mc", DA_V1, 1, 0);
        frame("R10 promisc uc", DA_V2, 1, 0);
        set_cfg(1, 0, 0, 0, 1, DA_V2, 32'h0, 32'h0);
        frame("R10 promisc over inverse", DA_V2, 1, 0);
    endtask

    task automatic t_framing;
        set_cfg(0, 0, 0, 0, 0, DA_V2, 32'h0, 32'h0);
        frame("R2 base frame", DA_V2, 1, 0);
        @(negedge clk);
        tests++;
        if (dec_vld !== 1'b0) begin
            fails++;
            $display("FAIL R2 pulse width: dec_vld %b exp 0", dec_vld);
        end
        // R2: trailing bytes without start-of-frame are ignored
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 8; i++) begin
                byte_vld = 1'b1; byte_sof = 1'b0; byte_data = 8'(i);
                @(negedge clk);
                if (dec_vld !== 1'b0) seen = 1'b1;
            end
            byte_vld = 1'b0;
            @(negedge clk);
            if (dec_vld !== 1'b0) seen = 1'b1;
            tests++;
            if (seen) begin
                fails++;
                $display("FAIL R2 extra bytes: dec_vld 1 exp 0");
            end
        end
        // R2: restart in the middle of an address
        @(negedge clk);
        byte_vld = 1'b1; byte_sof = 1'b1; byte_data = 8'h33;
        @(negedge clk);
        byte_sof = 1'b0; byte_data = 8'h44;
        @(negedge clk);
        byte_data = 8'h55;
        frame("R2 restart mid address", DA_V2, 1, 0);
        // R12: gaps between bytes
        send_da(DA_V2, 1'b1);
        expect_dec("R12 gapped exact", 1, 0);
        set_cfg(0, 0, 0, 1, 0, DA_U3, 32'h0000_1000, 32'h0);
        send_da(DA_V1, 1'b1);
        expect_dec("R12 gapped hash", 1, 0);
    endtask

    initial begin
        #(HALF * 2.0 * 100000.0);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_hash();
        t_perfect();
        t_pass_mcast();
        t_inverse();
        t_promisc();
        t_framing();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule